// File: doc/BRIEF.md
# Network Cache Line Coherence Controller

This block holds the coherence bookkeeping for one line of a station's network cache in a hierarchical multiprocessor whose stations are joined by a ring. It records whether the line is valid at this station and possibly shared by local processors (`LV`), held by exactly one local secondary cache (`LI`), or held somewhere else on the ring with no copy at this station (`GI`). It also records which local processors hold the line (processor mask) and which remote station holds it (routing mask). A busy state marks the line as locked while an exclusive-read transaction is in flight.

The controller takes the same part in the transaction as the station it sits in. When it sees a local exclusive read to a `GI` line it acts as requester: it sends the read toward the home station and waits for the data. When the line is valid here and another station asks for it, it acts as owner: it fetches the data from a local processor and puts it on the ring. When the line's home is this station and the line is held remotely, it acts as home: it passes the read on to the holder and waits until the data goes past. While locked, new work is refused rather than queued. All outputs are registered and appear one clock after the input that causes them.

Controller states: `CTL_IDLE`, `CTL_REQ_WAIT` (requester waiting for ring data), `CTL_OWN_WAIT` (owner waiting for its processor), `CTL_HOME_WAIT` (home waiting for the data to pass). Transitions: IDLE→REQ_WAIT on a local read to a `GI` line. IDLE→OWN_WAIT on a ring read to an `LV`/`LI` line with a local holder. IDLE→HOME_WAIT on a ring read to a `GI` line homed here. Each wait state returns to IDLE on its completing event.

Top module: `ncc_line_ctrl`

## Requirements
- R1: After reset the line is `LV` (encoding 0) with both masks zero, unlocked, and every valid, retry and nack output low. Line encodings: `LV`=0, `LI`=1, `GI`=2.
- R2: A local exclusive read (`lq_valid`) to an unlocked `LV` or `LI` line, with no ring packet that cycle, sends nothing to the ring and sets the line to `LI` with the processor mask one-hot at `lq_proc`.
- R3: A local exclusive read to an unlocked `GI` line locks the line, keeps it `GI`, and issues one ring request with source = `stn_id`, home = `lq_home`, destination mask one-hot at `lq_home`, or the routing mask when `lq_home` equals `stn_id`.
- R4: While waiting as requester, a data packet (`rx_kind`=1) whose source equals `stn_id` is passed to the saved processor with its payload. The line becomes `LI` with that processor alone in the mask, the routing mask clears, and the lock drops.
- R5: A ring exclusive read (`rx_kind`=0) from another station to an unlocked `LV`/`LI` line with a non-empty processor mask locks the line without changing its state and forwards the read to the lowest-numbered processor in the mask.
- R6: While waiting as owner, the processor's data return is put on the ring with the saved source and home IDs. The line becomes `GI`, the processor mask clears, the routing mask becomes one-hot at the requester's station, and the lock drops.
- R7: A ring exclusive read to an unlocked `LV` line with an empty processor mask is answered at once from the network cache copy (`INIT_VAL`). The line becomes `GI` with the routing mask one-hot at the requester, and no lock is taken.
- R8: A ring exclusive read from another station to an unlocked `GI` line whose home equals `stn_id` locks the line in `GI` and forwards a ring request with the same source, home = `stn_id`, and destination = current routing mask.
- R9: While waiting as home, a data packet with home = `stn_id` and the saved source drops the lock, keeps `GI`, sets the routing mask one-hot at that source, and sends nothing to local processors or the ring.
- R10: While locked, a local read is answered with `lq_retry` and a ring read with `tx_nack`; neither changes the line, the masks or the lock.
- R11: When a ring packet and a local read arrive in the same cycle, the ring packet is handled and the local read gets `lq_retry`.
- R12: Ignored, with no output and no state change: a ring read to a `GI` line not homed here, any ring read whose source is `stn_id` while unlocked, and any data packet that does not complete the current wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stn_id | input | SW | This station's ID |
| lq_valid | input | 1 | Local exclusive read request |
| lq_proc | input | PW | Requesting local processor |
| lq_home | input | SW | Home station of the requested line |
| lq_retry | output | 1 | Local request refused, retry later |
| rx_valid | input | 1 | Ring packet present |
| rx_kind | input | 1 | 0 = exclusive read, 1 = data response |
| rx_src | input | SW | Requesting station of the transaction |
| rx_home | input | SW | Home station of the line |
| rx_data | input | DW | Data payload |
| pr_valid | input | 1 | Local processor returns line data |
| pr_data | input | DW | Returned data |
| tx_req_valid | output | 1 | Exclusive read sent on the ring |
| tx_req_src | output | SW | Requester ID in the sent read |
| tx_req_home | output | SW | Home ID in the sent read |
| tx_req_dest | output | NSTN | Destination station mask |
| tx_data_valid | output | 1 | Data response sent on the ring |
| tx_data_src | output | SW | Requester ID the data is for |
| tx_data_home | output | SW | Home ID of the line |
| tx_data | output | DW | Data payload sent |
| tx_nack | output | 1 | Ring read refused, line locked |
| pp_req_valid | output | 1 | Exclusive read forwarded to a local processor |
| pp_req_proc | output | PW | Processor the read goes to |
| pd_valid | output | 1 | Data delivered to a local processor |
| pd_proc | output | PW | Receiving processor |
| pd_data | output | DW | Delivered data |
| st_line | output | 2 | Line state (0 LV, 1 LI, 2 GI) |
| st_locked | output | 1 | Transaction in flight |
| st_pmask | output | NPROC | Local processor mask |
| st_rmask | output | NSTN | Remote station routing mask |

## Verification
The bench drives one line through every role in turn, starting from the reset state: an immediate reply from the cache copy, a requester round trip, a handoff at the owner, a pass-through at the home, and a requester whose home is itself. A design that used the home ID instead of the routing mask when it is its own home would send its request back to itself. A design that updated the routing mask from the home's ignored payload, or forwarded it to a processor, would show stray data or the wrong holder. Locked-line probes check that retry and nack leave state untouched and that nothing is queued. A same-cycle collision between a ring read and a local read shows whether the local side is wrongly served. Foreign data and self-sourced reads must produce no output at all.

// File: rtl/ncc_pkg.sv
package ncc_pkg;

    typedef enum logic [1:0] {
        LINE_LV = 2'd0,
        LINE_LI = 2'd1,
        LINE_GI = 2'd2
    } line_e;

    typedef enum logic [1:0] {
        CTL_IDLE      = 2'd0,
        CTL_REQ_WAIT  = 2'd1,
        CTL_OWN_WAIT  = 2'd2,
        CTL_HOME_WAIT = 2'd3
    } ctl_e;

    localparam logic PKT_RDEX = 1'b0;
    localparam logic PKT_DATA = 1'b1;

endpackage

// File: rtl/ncc_role_dec.sv
module ncc_role_dec #(
    parameter int SW = 3
) (
    input  logic [SW-1:0] my_id,
    input  logic [SW-1:0] pkt_src,
    input  logic [SW-1:0] pkt_home,
    output logic          from_self,
    output logic          at_home
);
    // Role of this station for one packet
    assign from_self = (pkt_src == my_id);
    assign at_home   = (pkt_home == my_id);
endmodule

// File: rtl/ncc_onehot.sv
module ncc_onehot #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [IW-1:0] idx,
    output logic [N-1:0]  mask
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        assign mask[g] = (idx == IW'(g));
    end
endmodule

// File: rtl/ncc_pick_low.sv
module ncc_pick_low #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  mask,
    output logic [IW-1:0] idx,
    output logic          any
);
    assign any = |mask;

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/ncc_line_ctrl.sv
module ncc_line_ctrl
    import ncc_pkg::*;
#(
    parameter int          NPROC    = 4,
    parameter int          NSTN     = 8,
    parameter int          DW       = 32,
    parameter logic [DW-1:0] INIT_VAL = '0,
    localparam int         PW       = (NPROC > 1) ? $clog2(NPROC) : 1,
    localparam int         SW       = (NSTN > 1) ? $clog2(NSTN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SW-1:0]    stn_id,
    input  logic             lq_valid,
    input  logic [PW-1:0]    lq_proc,
    input  logic [SW-1:0]    lq_home,
    output logic             lq_retry,
    input  logic             rx_valid,
    input  logic             rx_kind,
    input  logic [SW-1:0]    rx_src,
    input  logic [SW-1:0]    rx_home,
    input  logic [DW-1:0]    rx_data,
    input  logic             pr_valid,
    input  logic [DW-1:0]    pr_data,
    output logic             tx_req_valid,
    output logic [SW-1:0]    tx_req_src,
    output logic [SW-1:0]    tx_req_home,
    output logic [NSTN-1:0]  tx_req_dest,
    output logic             tx_data_valid,
    output logic [SW-1:0]    tx_data_src,
    output logic [SW-1:0]    tx_data_home,
    output logic [DW-1:0]    tx_data,
    output logic             tx_nack,
    output logic             pp_req_valid,
    output logic [PW-1:0]    pp_req_proc,
    output logic             pd_valid,
    output logic [PW-1:0]    pd_proc,
    output logic [DW-1:0]    pd_data,
    output logic [1:0]       st_line,
    output logic             st_locked,
    output logic [NPROC-1:0] st_pmask,
    output logic [NSTN-1:0]  st_rmask
);

    // ---------------- state ----------------
    line_e             line_q, line_d;
    ctl_e              ctl_q, ctl_d;
    logic [NPROC-1:0]  pmask_q, pmask_d;
    logic [NSTN-1:0]   rmask_q, rmask_d;
    logic [PW-1:0]     sv_proc_q, sv_proc_d;
    logic [SW-1:0]     sv_src_q, sv_src_d;
    logic [SW-1:0]     sv_home_q, sv_home_d;

    // ---------------- next outputs ----------------
    logic              n_retry, n_nack;
    logic              n_req_v;
    logic [SW-1:0]     n_req_src, n_req_home;
    logic [NSTN-1:0]   n_req_dest;
    logic              n_dat_v;
    logic [SW-1:0]     n_dat_src, n_dat_home;
    logic [DW-1:0]     n_dat;
    logic              n_pp_v;
    logic [PW-1:0]     n_pp_proc;
    logic              n_pd_v;
    logic [PW-1:0]     n_pd_proc;
    logic [DW-1:0]     n_pd_data;

    // ---------------- decode helpers ----------------
    logic              rx_from_self, rx_at_home;
    logic              lq_unused_self, lq_at_home;
    logic [NPROC-1:0]  lq_pmask, sv_pmask;
    logic [NSTN-1:0]   src_rmask, lqhome_rmask, sv_rmask;
    logic [PW-1:0]     pick_idx;
    logic              pick_any;

    ncc_role_dec #(.SW(SW)) u_rx_role (
        .my_id     (stn_id),
        .pkt_src   (rx_src),
        .pkt_home  (rx_home),
        .from_self (rx_from_self),
        .at_home   (rx_at_home)
    );

    ncc_role_dec #(.SW(SW)) u_lq_role (
        .my_id     (stn_id),
        .pkt_src   (stn_id),
        .pkt_home  (lq_home),
        .from_self (lq_unused_self),
        .at_home   (lq_at_home)
    );

    ncc_onehot #(.N(NPROC), .IW(PW)) u_oh_lq   (.idx(lq_proc),   .mask(lq_pmask));
    ncc_onehot #(.N(NPROC), .IW(PW)) u_oh_svp  (.idx(sv_proc_q), .mask(sv_pmask));
    ncc_onehot #(.N(NSTN),  .IW(SW)) u_oh_src  (.idx(rx_src),    .mask(src_rmask));
    ncc_onehot #(.N(NSTN),  .IW(SW)) u_oh_home (.idx(lq_home),   .mask(lqhome_rmask));
    ncc_onehot #(.N(NSTN),  .IW(SW)) u_oh_svs  (.idx(sv_src_q),  .mask(sv_rmask));

    ncc_pick_low #(.N(NPROC), .IW(PW)) u_pick (
        .mask (pmask_q),
        .idx  (pick_idx),
        .any  (pick_any)
    );

    logic rx_rdex, rx_dat;
    assign rx_rdex = rx_valid && (rx_kind == PKT_RDEX);
    assign rx_dat  = rx_valid && (rx_kind == PKT_DATA);

    // ---------------- next-state and output logic ----------------
    always_comb begin
        line_d     = line_q;
        ctl_d      = ctl_q;
        pmask_d    = pmask_q;
        rmask_d    = rmask_q;
        sv_proc_d  = sv_proc_q;
        sv_src_d   = sv_src_q;
        sv_home_d  = sv_home_q;

        n_retry    = 1'b0;
        n_nack     = 1'b0;
        n_req_v    = 1'b0;
        n_req_src  = '0;
        n_req_home = '0;
        n_req_dest = '0;
        n_dat_v    = 1'b0;
        n_dat_src  = '0;
        n_dat_home = '0;
        n_dat      = '0;
        n_pp_v     = 1'b0;
        n_pp_proc  = '0;
        n_pd_v     = 1'b0;
        n_pd_proc  = '0;
        n_pd_data  = '0;

        unique case (ctl_q)
            CTL_IDLE: begin
                if (rx_valid) begin
                    // ring traffic wins over a local request this cycle
                    n_retry = lq_valid;
                    if (rx_rdex && !rx_from_self) begin
                        if (line_q != LINE_GI) begin
                            if (pick_any) begin
                                // owner: lock in place, ask local holder
                                ctl_d     = CTL_OWN_WAIT;
                                sv_src_d  = rx_src;
                                sv_home_d = rx_home;
                                n_pp_v    = 1'b1;
                                n_pp_proc = pick_idx;
                            end else begin
                                // owner with no local holder: reply from cache copy
                                n_dat_v    = 1'b1;
                                n_dat_src  = rx_src;
                                n_dat_home = rx_home;
                                n_dat      = INIT_VAL;
                                line_d     = LINE_GI;
                                pmask_d    = '0;
                                rmask_d    = src_rmask;
                            end
                        end else if (rx_at_home) begin
                            // home: lock in GI, pass read to the holder
                            ctl_d      = CTL_HOME_WAIT;
                            sv_src_d   = rx_src;
                            n_req_v    = 1'b1;
                            n_req_src  = rx_src;
                            n_req_home = stn_id;
                            n_req_dest = rmask_q;
                        end
                    end
                end else if (lq_valid) begin
                    if (line_q == LINE_GI) begin
                        // requester: lock in GI, go to home
                        ctl_d      = CTL_REQ_WAIT;
                        sv_proc_d  = lq_proc;
                        n_req_v    = 1'b1;
                        n_req_src  = stn_id;
                        n_req_home = lq_home;
                        n_req_dest = lq_at_home ? rmask_q : lqhome_rmask;
                    end else begin
                        line_d  = LINE_LI;
                        pmask_d = lq_pmask;
                    end
                end
            end

            CTL_REQ_WAIT: begin
                n_retry = lq_valid;
                n_nack  = rx_rdex;
                if (rx_dat && rx_from_self) begin
                    n_pd_v    = 1'b1;
                    n_pd_proc = sv_proc_q;
                    n_pd_data = rx_data;
                    line_d    = LINE_LI;
                    pmask_d   = sv_pmask;
                    rmask_d   = '0;
                    ctl_d     = CTL_IDLE;
                end
            end

            CTL_OWN_WAIT: begin
                n_retry = lq_valid;
                n_nack  = rx_rdex;
                if (pr_valid) begin
                    n_dat_v    = 1'b1;
                    n_dat_src  = sv_src_q;
                    n_dat_home = sv_home_q;
                    n_dat      = pr_data;
                    line_d     = LINE_GI;
                    pmask_d    = '0;
                    rmask_d    = sv_rmask;
                    ctl_d      = CTL_IDLE;
                end
            end

            CTL_HOME_WAIT: begin
                n_retry = lq_valid;
                n_nack  = rx_rdex;
                if (rx_dat && rx_at_home && (rx_src == sv_src_q)) begin
                    // payload is not kept; only the holder changes
                    rmask_d = sv_rmask;
                    ctl_d   = CTL_IDLE;
                end
            end

            default: ctl_d = CTL_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q    <= LINE_LV;
            ctl_q     <= CTL_IDLE;
            pmask_q   <= '0;
            rmask_q   <= '0;
            sv_proc_q <= '0;
            sv_src_q  <= '0;
            sv_home_q <= '0;
        end else begin
            line_q    <= line_d;
            ctl_q     <= ctl_d;
            pmask_q   <= pmask_d;
            rmask_q   <= rmask_d;
            sv_proc_q <= sv_proc_d;
            sv_src_q  <= sv_src_d;
            sv_home_q <= sv_home_d;
        end
    end

    // ---------------- output register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lq_retry      <= 1'b0;
            tx_nack       <= 1'b0;
            tx_req_valid  <= 1'b0;
            tx_req_src    <= '0;
            tx_req_home   <= '0;
            tx_req_dest   <= '0;
            tx_data_valid <= 1'b0;
            tx_data_src   <= '0;
            tx_data_home  <= '0;
            tx_data       <= '0;
            pp_req_valid  <= 1'b0;
            pp_req_proc   <= '0;
            pd_valid      <= 1'b0;
            pd_proc       <= '0;
            pd_data       <= '0;
        end else begin
            lq_retry      <= n_retry;
            tx_nack       <= n_nack;
            tx_req_valid  <= n_req_v;
            tx_req_src    <= n_req_src;
            tx_req_home   <= n_req_home;
            tx_req_dest   <= n_req_dest;
            tx_data_valid <= n_dat_v;
            tx_data_src   <= n_dat_src;
            tx_data_home  <= n_dat_home;
            tx_data       <= n_dat;
            pp_req_valid  <= n_pp_v;
            pp_req_proc   <= n_pp_proc;
            pd_valid      <= n_pd_v;
            pd_proc       <= n_pd_proc;
            pd_data       <= n_pd_data;
        end
    end

    assign st_line   = line_q;
    assign st_locked = (ctl_q != CTL_IDLE);
    assign st_pmask  = pmask_q;
    assign st_rmask  = rmask_q;

    logic unused_ok;
    assign unused_ok = lq_unused_self;

endmodule

// File: rtl/ncc_line_ctrl_chk.sv
module ncc_line_ctrl_chk
    import ncc_pkg::*;
#(
    parameter int NPROC = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lq_valid,
    input logic             lq_retry,
    input logic             rx_valid,
    input logic             rx_kind,
    input logic             tx_nack,
    input logic             pd_valid,
    input logic [1:0]       st_line,
    input logic             st_locked,
    input logic [NPROC-1:0] st_pmask
);

    AST_LOCAL_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        st_locked && lq_valid |=> lq_retry); // R10

    AST_RING_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        st_locked && rx_valid && (rx_kind == PKT_RDEX) |=> tx_nack); // R10

    AST_LOCK_HOLDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        st_locked |-> $stable(st_line)); // R5

    AST_LI_SINGLE_HOLDER: assert property (@(posedge clk) disable iff (!rst_n)
        (st_line == LINE_LI) |-> ($countones(st_pmask) == 1)); // R4

    AST_GI_NO_LOCAL_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_line == LINE_GI) |-> (st_pmask == '0)); // R6

    AST_DELIVERY_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        pd_valid |-> ((st_line == LINE_LI) && !st_locked)); // R4

    AST_RING_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && lq_valid |=> lq_retry); // R11

endmodule

bind ncc_line_ctrl ncc_line_ctrl_chk #(.NPROC(NPROC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lq_valid  (lq_valid),
    .lq_retry  (lq_retry),
    .rx_valid  (rx_valid),
    .rx_kind   (rx_kind),
    .tx_nack   (tx_nack),
    .pd_valid  (pd_valid),
    .st_line   (st_line),
    .st_locked (st_locked),
    .st_pmask  (st_pmask)
);

// File: tb/tb_ncc_line_ctrl.sv
module tb_ncc_line_ctrl;

    localparam int NP = 4;
    localparam int NS = 8;
    localparam int DW = 32;
    localparam int PW = 2;
    localparam int SW = 3;
    localparam logic [SW-1:0] MY = 3'd3;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n;
    logic lq_valid; logic [PW-1:0] lq_proc; logic [SW-1:0] lq_home;
    logic rx_valid, rx_kind; logic [SW-1:0] rx_src, rx_home; logic [DW-1:0] rx_data;
    logic pr_valid; logic [DW-1:0] pr_data;
    logic lq_retry, tx_nack;
    logic tx_req_valid; logic [SW-1:0] tx_req_src, tx_req_home; logic [NS-1:0] tx_req_dest;
    logic tx_data_valid; logic [SW-1:0] tx_data_src, tx_data_home; logic [DW-1:0] tx_data;
    logic pp_req_valid; logic [PW-1:0] pp_req_proc;
    logic pd_valid; logic [PW-1:0] pd_proc; logic [DW-1:0] pd_data;
    logic [1:0] st_line; logic st_locked; logic [NP-1:0] st_pmask; logic [NS-1:0] st_rmask;

    ncc_line_ctrl #(.NPROC(NP), .NSTN(NS), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .stn_id(MY),
        .lq_valid(lq_valid), .lq_proc(lq_proc), .lq_home(lq_home), .lq_retry(lq_retry),
        .rx_valid(rx_valid), .rx_kind(rx_kind), .rx_src(rx_src), .rx_home(rx_home), .rx_data(rx_data),
        .pr_valid(pr_valid), .pr_data(pr_data),
        .tx_req_valid(tx_req_valid), .tx_req_src(tx_req_src), .tx_req_home(tx_req_home), .tx_req_dest(tx_req_dest),
        .tx_data_valid(tx_data_valid), .tx_data_src(tx_data_src), .tx_data_home(tx_data_home), .tx_data(tx_data),
        .tx_nack(tx_nack), .pp_req_valid(pp_req_valid), .pp_req_proc(pp_req_proc),
        .pd_valid(pd_valid), .pd_proc(pd_proc), .pd_data(pd_data),
        .st_line(st_line), .st_locked(st_locked), .st_pmask(st_pmask), .st_rmask(st_rmask)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [63:0] exp_q[$];
    string       tag_q[$];

    // item: kind(4) f1(8) f2(8) f3(8) data(32), top 4 bits zero
    function automatic logic [63:0] mk(int k, int f1, int f2, int f3, logic [31:0] d);
        return {4'd0, 4'(k), 8'(f1), 8'(f2), 8'(f3), d};
    endfunction

    task automatic expect_item(logic [63:0] it, string tag);
        exp_q.push_back(it);
        tag_q.push_back(tag);
    endtask

    task automatic observe(logic [63:0] it);
        checks++;
        if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL unexpected output: actual %h expected none", it);
        end else begin
            logic [63:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (e !== it) begin
                fails++;
                $display("FAIL %s: actual %h expected %h", t, it, e);
            end
        end
    endtask

    // monitor: fixed order retry, nack, ring req, ring data, proc req, proc data
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (lq_retry)      observe(mk(1, 0, 0, 0, 0));
            if (tx_nack)       observe(mk(2, 0, 0, 0, 0));
            if (tx_req_valid)  observe(mk(3, tx_req_src, tx_req_home, tx_req_dest, 0));
            if (tx_data_valid) observe(mk(4, tx_data_src, tx_data_home, 0, tx_data));
            if (pp_req_valid)  observe(mk(5, pp_req_proc, 0, 0, 0));
            if (pd_valid)      observe(mk(6, pd_proc, 0, 0, pd_data));
        end
    end

    task automatic idle_inputs();
        lq_valid = 0; lq_proc = '0; lq_home = '0;
        rx_valid = 0; rx_kind = 0; rx_src = '0; rx_home = '0; rx_data = '0;
        pr_valid = 0; pr_data = '0;
    endtask

    // one cycle of stimulus, starting and ending at a falling edge
    task automatic drive(bit lv, int lp, int lh, bit rv, bit rk, int rs, int rh,
                         logic [31:0] rd, bit pv, logic [31:0] pdv);
        lq_valid = lv; lq_proc = PW'(lp); lq_home = SW'(lh);
        rx_valid = rv; rx_kind = rk; rx_src = SW'(rs); rx_home = SW'(rh); rx_data = rd;
        pr_valid = pv; pr_data = pdv;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic local_rd(int p, int h);
        drive(1, p, h, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic ring(bit k, int s, int h, logic [31:0] d);
        drive(0, 0, 0, 1, k, s, h, d, 0, 0);
    endtask

    task automatic proc_ret(logic [31:0] d);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1, d);
    endtask

    task automatic check_state(int ln, bit lk, int pm, int rm, string tag);
        checks++;
        if (st_line !== 2'(ln) || st_locked !== lk || st_pmask !== NP'(pm) || st_rmask !== NS'(rm)) begin
            fails++;
            $display("FAIL %s: actual line=%0d lock=%0b pmask=%b rmask=%b expected line=%0d lock=%0b pmask=%b rmask=%b",
                     tag, st_line, st_locked, st_pmask, st_rmask, ln, lk, NP'(pm), NS'(rm));
        end
    endtask

    task automatic check_outputs_idle(string tag);
        logic [5:0] v;
        v = {lq_retry, tx_nack, tx_req_valid, tx_data_valid, pp_req_valid, pd_valid};
        checks++;
        if (v !== 6'b0) begin
            fails++;
            $display("FAIL %s: actual valids=%b expected 000000", tag, v);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        do_reset();
        // R1 reset state
        check_state(0, 0, 0, 0, "R1");
        check_outputs_idle("R1");

        // R7 reply from cache copy when no local holder
        expect_item(mk(4, 5, 1, 0, 32'h0), "R7");
        ring(0, 5, 1, 0);
        check_state(2, 0, 0, 8'h20, "R7");

        // R12 read to GI line not homed here, stray data, self-sourced read
        ring(0, 6, 1, 0);
        check_state(2, 0, 0, 8'h20, "R12");
        ring(1, 2, 1, 32'h1111);
        check_state(2, 0, 0, 8'h20, "R12");
        ring(0, 3, 1, 0);
        check_state(2, 0, 0, 8'h20, "R12");

        // R3 requester sends read to home
        expect_item(mk(3, 3, 1, 8'h02, 0), "R3");
        local_rd(2, 1);
        check_state(2, 1, 0, 8'h20, "R3");

        // R10 locked line refuses new work
        expect_item(mk(1, 0, 0, 0, 0), "R10");
        local_rd(1, 1);
        check_state(2, 1, 0, 8'h20, "R10");
        expect_item(mk(2, 0, 0, 0, 0), "R10");
        ring(0, 6, 1, 0);
        check_state(2, 1, 0, 8'h20, "R10");
        ring(1, 4, 1, 32'h2222);   // R12 data for another requester
        check_state(2, 1, 0, 8'h20, "R12");

        // R4 data returns to requester
        expect_item(mk(6, 2, 0, 0, 32'hCAFE0001), "R4");
        ring(1, 3, 1, 32'hCAFE0001);
        check_state(1, 0, 4'b0100, 0, "R4");

        // R2 local read to LI line
        local_rd(0, 1);
        check_state(1, 0, 4'b0001, 0, "R2");

        // R5 owner forwards to local holder
        expect_item(mk(5, 0, 0, 0, 0), "R5");
        ring(0, 7, 0, 0);
        check_state(1, 1, 4'b0001, 0, "R5");

        // R6 owner hands data to the ring
        expect_item(mk(4, 7, 0, 0, 32'h00001234), "R6");
        proc_ret(32'h00001234);
        check_state(2, 0, 0, 8'h80, "R6");

        // R8 home passes read to the holder
        expect_item(mk(3, 5, 3, 8'h80, 0), "R8");
        ring(0, 5, 3, 0);
        check_state(2, 1, 0, 8'h80, "R8");
        ring(1, 4, 3, 32'h3333);   // R12 wrong source at home
        check_state(2, 1, 0, 8'h80, "R12");

        // R9 home sees data pass, ignores payload
        ring(1, 5, 3, 32'h4444);
        check_state(2, 0, 0, 8'h20, "R9");

        // R3 requester that is its own home uses routing mask
        expect_item(mk(3, 3, 3, 8'h20, 0), "R3");
        local_rd(1, 3);
        check_state(2, 1, 0, 8'h20, "R3");
        expect_item(mk(6, 1, 0, 0, 32'h0000BEEF), "R4");
        ring(1, 3, 3, 32'h0000BEEF);
        check_state(1, 0, 4'b0010, 0, "R4");

        // R11 ring read and local read in the same cycle
        expect_item(mk(1, 0, 0, 0, 0), "R11");
        expect_item(mk(5, 1, 0, 0, 0), "R11");
        drive(1, 2, 1, 1, 0, 6, 0, 0, 0, 0);
        check_state(1, 1, 4'b0010, 0, "R11");
        expect_item(mk(4, 6, 0, 0, 32'h00000055), "R6");
        proc_ret(32'h00000055);
        check_state(2, 0, 0, 8'h40, "R6");

        // R12 self-sourced read while unlocked
        ring(0, 3, 0, 0);
        check_state(2, 0, 0, 8'h40, "R12");

        // R2 local read on a fresh LV line
        do_reset();
        check_state(0, 0, 0, 0, "R1");
        local_rd(3, 0);
        check_state(1, 0, 4'b1000, 0, "R2");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: actual %0d items pending expected 0", exp_q.size());
        end
        report();
    end

endmodule